// File: doc/BRIEF.md
# Dual-slope PWM timer with two compare channels

A 16-bit counter runs up from zero to a programmable turning value (TOP), then back down to zero, and repeats. The counter moves only on timer ticks. An in-block divider makes those ticks either on every system clock or on every eighth clock. Two compare channels, A and B, compare their active compare value with the counter, and each drives one PWM pin. Because the waveform is symmetric around TOP, the pulse stays centred in every period.

Software writes compare values into shadow buffers. The timer copies those buffers into the active compare values only when the counter arrives at zero, so a period never mixes an old and a new duty. There are three sticky flags: one for each channel's compare match and one for arrival at zero. Software clears a flag by writing a one to its bit. Channel A's active compare value can also serve as TOP. In that case channel A can toggle on each match and gives an exact half-duty square wave.

Top module: `pwm_ds_timer`

## Requirements
- R1: The counter takes values 0,1,…,TOP then TOP-1,…,1 and repeats, so one period lasts 2*TOP ticks. The up phase covers values 0..TOP-1 and the down phase covers values TOP..1. A TOP of 0 behaves as 1.
- R2: The counter changes only on a timer tick, and it changes by exactly one on every tick.
- R3: With control bit 5 clear, a tick occurs on every clock. With control bit 5 set, a tick occurs on every eighth clock.
- R4: A write to address 1 (channel A) or address 2 (channel B) updates only that channel's buffer. The active compare value takes the buffer value on the tick where the counter arrives at 0.
- R5: Flag output flag_ovf sets on the tick where the counter arrives at 0.
- R6: flag_a and flag_b set on the tick that leaves a counter value equal to the channel's active compare value. Writing address 4 clears the flags whose data bits are one (bit 0 for A, bit 1 for B, bit 2 for overflow). Reset clears every flag.
- R7: In mode 2 (non-inverting), the output is high in the up phase while the counter is below the compare value, and in the down phase while the counter is at or below it. This gives 2*compare high ticks per period.
- R8: In mode 2, a compare value of 0 keeps the output low for the whole period. A compare value at or above TOP keeps it high for the whole period.
- R9: Mode 3 (inverting) gives the complement of mode 2 for every compare value, extremes included.
- R10: With control bit 4 set, TOP is channel A's active compare value. If channel A is then in mode 1 (toggle), pin A inverts on each match, which gives high and low spans of 2*TOP ticks each.
- R11: Mode 0 holds the output low. Mode 1 on channel B holds it low, and so does mode 1 on channel A while control bit 4 is clear.
- R12: Address 0 writes TOP. Address 3 writes the control word: bits 1:0 are channel A's mode, bits 3:2 are channel B's mode, bit 4 selects A as TOP, and bit 5 selects the slow tick. Reset sets TOP, the buffers, the active compare values, the control word and the counter to zero, with the direction set to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..4) |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| flag_a | output | 1 | Channel A compare-match flag |
| flag_b | output | 1 | Channel B compare-match flag |
| flag_ovf | output | 1 | Arrival-at-zero flag |
| cnt_o | output | 16 | Current counter value |

## Verification
The hardest case to reach is a buffer write that lands mid-period. A design that applies the new compare value at once instead of at zero differs only in the high ticks that remain before the next zero. The bench waits until the counter sits at TOP, writes a much larger compare value, and counts the high ticks down to zero. It then counts a full period to see the new value take effect. Each tick is detected by a change in the counter, so the same stimulus exercises both tick rates with no knowledge of the internal divider phase.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'b00,
    OUT_TOGGLE = 2'b01,
    OUT_NONINV = 2'b10,
    OUT_INV    = 2'b11
  } out_mode_e;

  localparam logic [2:0] ADR_TOP   = 3'd0;
  localparam logic [2:0] ADR_CMPA  = 3'd1;
  localparam logic [2:0] ADR_CMPB  = 3'd2;
  localparam logic [2:0] ADR_CTRL  = 3'd3;
  localparam logic [2:0] ADR_FLAGS = 3'd4;

  localparam int CTRL_W      = 6;
  localparam int CB_TOP_SEL  = 4;
  localparam int CB_SLOW     = 5;
endpackage

// File: rtl/pwm_ds_prescale.sv
module pwm_ds_prescale #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  output logic tick
);
  logic [DIV_LOG2-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = slow_sel ? (&pre_q) : 1'b1;

  // R3: in slow mode two ticks are never adjacent
  a_r3_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sel && tick ##1 slow_sel) |-> !tick);
  // R3: in fast mode every clock is a tick
  a_r3_fast_every: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_sel |-> tick);
endmodule

// File: rtl/pwm_ds_counter.sv
module pwm_ds_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] top_req,
  output logic [CW-1:0] cnt,
  output logic          up,
  output logic [CW-1:0] top_eff,
  output logic          bottom_hit
);
  logic [CW-1:0] cnt_nxt;
  logic          up_nxt;

  function automatic logic [CW-1:0] clamp_top(input logic [CW-1:0] t);
    return (t == '0) ? {{(CW-1){1'b0}}, 1'b1} : t;
  endfunction

  // returns {direction after step, counter after step}
  function automatic logic [CW:0] step(input logic [CW-1:0] c,
                                       input logic u,
                                       input logic [CW-1:0] t);
    logic [CW-1:0] n;
    logic          nu;
    if (u && c < t) begin
      n  = c + 1'b1;
      nu = (n < t);
    end else if (c != '0) begin
      n  = c - 1'b1;
      nu = (n == '0);
    end else begin
      n  = {{(CW-1){1'b0}}, 1'b1};
      nu = 1'b1;
    end
    return {nu, n};
  endfunction

  assign top_eff            = clamp_top(top_req);
  assign {up_nxt, cnt_nxt}  = step(cnt, up, top_eff);
  assign bottom_hit         = tick && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      cnt <= cnt_nxt;
      up  <= up_nxt;
    end
  end

  // R1: every tick moves the counter by exactly one
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));
  // R1: the counter turns downward after sitting on TOP
  a_r1_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == top_eff) |=> cnt < $past(cnt));
  // R2: without a tick the counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt) && $stable(up));
  // R1: at zero the direction is always up
  a_r1_zero_up: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> up);
endmodule

// File: rtl/pwm_ds_channel.sv
module pwm_ds_channel
  import pwm_ds_pkg::*;
#(
  parameter int CW         = 16,
  parameter bit HAS_TOGGLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] buf_val,
  input  out_mode_e     mode,
  input  logic          toggle_ok,
  output logic          pwm,
  output logic          match,
  output logic [CW-1:0] cmp_act
);
  logic tgl_q;
  logic lvl;

  function automatic logic pwm_level(input logic [CW-1:0] c,
                                     input logic [CW-1:0] cmp,
                                     input logic [CW-1:0] t,
                                     input logic u);
    if (cmp == '0)      return 1'b0;
    else if (cmp >= t)  return 1'b1;
    else if (u)         return c < cmp;
    else                return c <= cmp;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cmp_act <= '0;
    else if (load) cmp_act <= buf_val;
  end

  assign match = (cnt == cmp_act);
  assign lvl   = pwm_level(cnt, cmp_act, top, up);

  generate
    if (HAS_TOGGLE) begin : g_tgl
      always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else if (tick && match && toggle_ok && mode == OUT_TOGGLE) tgl_q <= ~tgl_q;
      end
    end else begin : g_no_tgl
      assign tgl_q = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      OUT_OFF:    pwm = 1'b0;
      OUT_TOGGLE: pwm = toggle_ok && tgl_q;
      OUT_NONINV: pwm = lvl;
      OUT_INV:    pwm = ~lvl;
      default:    pwm = 1'b0;
    endcase
  end

  // R4: active compare value changes only on a load at zero
  a_r4_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_act));
  // R8: compare of zero keeps the non-inverted pin low
  a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_NONINV && cmp_act == '0) |-> !pwm);
  // R8: compare at or above TOP keeps the non-inverted pin high
  a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_NONINV && cmp_act != '0 && cmp_act >= top) |-> pwm);
  // R9: inverted pin high at the zero extreme
  a_r9_inv_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_INV && cmp_act == '0) |-> pwm);
  // R11: disabled output stays low
  a_r11_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_OFF) |-> !pwm);
endmodule

// File: rtl/pwm_ds_timer.sv
module pwm_ds_timer
  import pwm_ds_pkg::*;
#(
  parameter int CW       = 16,
  parameter int DIV_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          flag_a,
  output logic          flag_b,
  output logic          flag_ovf,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0]     top_reg, buf_a, buf_b;
  logic [CTRL_W-1:0] ctrl;
  logic [2:0]        flag_clr;
  logic              tick, up, bottom_hit, match_a, match_b;
  logic [CW-1:0]     top_eff, cmp_act_a, cmp_act_b, top_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_reg <= '0;
      buf_a   <= '0;
      buf_b   <= '0;
      ctrl    <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADR_TOP:  top_reg <= wr_data;
        ADR_CMPA: buf_a   <= wr_data;
        ADR_CMPB: buf_b   <= wr_data;
        ADR_CTRL: ctrl    <= wr_data[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  assign flag_clr = (wr_en && wr_addr == ADR_FLAGS) ? wr_data[2:0] : 3'b000;
  assign top_req  = ctrl[CB_TOP_SEL] ? cmp_act_a : top_reg;

  pwm_ds_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_sel(ctrl[CB_SLOW]), .tick(tick));

  pwm_ds_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_req(top_req),
    .cnt(cnt_o), .up(up), .top_eff(top_eff), .bottom_hit(bottom_hit));

  pwm_ds_channel #(.CW(CW), .HAS_TOGGLE(1'b1)) u_ch_a (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(bottom_hit), .cnt(cnt_o),
    .up(up), .top(top_eff), .buf_val(buf_a), .mode(out_mode_e'(ctrl[1:0])),
    .toggle_ok(ctrl[CB_TOP_SEL]), .pwm(pwm_a), .match(match_a), .cmp_act(cmp_act_a));

  pwm_ds_channel #(.CW(CW), .HAS_TOGGLE(1'b0)) u_ch_b (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(bottom_hit), .cnt(cnt_o),
    .up(up), .top(top_eff), .buf_val(buf_b), .mode(out_mode_e'(ctrl[3:2])),
    .toggle_ok(1'b0), .pwm(pwm_b), .match(match_b), .cmp_act(cmp_act_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      flag_ovf <= 1'b0;
    end else begin
      flag_a   <= (flag_a   & ~flag_clr[0]) | (tick & match_a);
      flag_b   <= (flag_b   & ~flag_clr[1]) | (tick & match_b);
      flag_ovf <= (flag_ovf & ~flag_clr[2]) | bottom_hit;
    end
  end

  // R6: a match on a tick raises the channel flag
  a_r6_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_a) |=> flag_a);
  a_r6_set_b: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_b) |=> flag_b);
  // R5: arrival at zero raises the overflow flag
  a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    bottom_hit |=> flag_ovf);
  // R6: a flag stays set until written with one
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf && !flag_clr[2]) |=> flag_ovf);
  // R4: loads coincide with the counter reaching zero
  a_r4_load_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bottom_hit |=> cnt_o == '0);
endmodule

// File: tb/pwm_ds_timer_bench.sv
`timescale 1ns/1ps
module pwm_ds_timer_bench;
  localparam int CW = 16;
  localparam int M_OFF = 0, M_TGL = 1, M_NI = 2, M_INV = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          pwm_a, pwm_b, flag_a, flag_b, flag_ovf;
  logic [CW-1:0] cnt_o;

  pwm_ds_timer u_pwm_ds_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_a(flag_a), .flag_b(flag_b),
    .flag_ovf(flag_ovf), .cnt_o(cnt_o));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int tick_clks = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(input int mode, input int cmp, input int top);
    int t, base;
    t = (top == 0) ? 1 : top;
    base = (cmp == 0) ? 0 : ((cmp >= t) ? 2 * t : 2 * cmp);
    case (mode)
      M_NI:    return base;
      M_INV:   return 2 * t - base;
      default: return 0;
    endcase
  endfunction

  function automatic int mk_ctrl(input int ma, input int mb, input int tsel, input int slow);
    return ma | (mb << 2) | (tsel << 4) | (slow << 5);
  endfunction

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic next_tick();
    logic [CW-1:0] p;
    p = cnt_o;
    tick_clks = 0;
    do begin
      @(negedge clk);
      tick_clks++;
    end while (cnt_o == p);
  endtask

  task automatic sync_bottom();
    do next_tick(); while (cnt_o != 0);
  endtask

  task automatic measure(output int ticks, output int hia, output int hib,
                         output int clks, output int peak, output int bad_gap,
                         input int gap);
    ticks = 0; hia = 0; hib = 0; clks = 0; peak = 0; bad_gap = 0;
    do begin
      hia += int'(pwm_a);
      hib += int'(pwm_b);
      if (int'(cnt_o) > peak) peak = int'(cnt_o);
      next_tick();
      if (tick_clks != gap) bad_gap++;
      clks += tick_clks;
      ticks++;
    end while (cnt_o != 0);
  endtask

  task automatic run_pwm(input int top, input int ca, input int cb,
                         input int ma, input int mb, input int slow, input string tag);
    int ticks, hia, hib, clks, peak, bad, t;
    t = (top == 0) ? 1 : top;
    wr(3'd0, top);
    wr(3'd1, ca);
    wr(3'd2, cb);
    wr(3'd3, mk_ctrl(ma, mb, 0, slow));
    sync_bottom();
    measure(ticks, hia, hib, clks, peak, bad, slow ? 8 : 1);
    chk("R1 period ticks", ticks, 2 * t);
    chk("R1 peak value", peak, t);
    chk("R2 tick spacing", bad, 0);
    chk("R3 period clocks", clks, 2 * t * (slow ? 8 : 1));
    chk({tag, " high ticks A"}, hia, exp_hi(ma, ca, t));
    chk({tag, " high ticks B"}, hib, exp_hi(mb, cb, t));
  endtask

  task automatic buffer_test(input int slow);
    int hia, ticks, hib, clks, peak, bad;
    wr(3'd0, 20);
    wr(3'd1, 5);
    wr(3'd3, mk_ctrl(M_NI, M_OFF, 0, slow));
    sync_bottom();
    sync_bottom();
    while (cnt_o != 20) next_tick();
    wr(3'd1, 15);
    hia = 0;
    do begin
      hia += int'(pwm_a);
      next_tick();
    end while (cnt_o != 0);
    chk("R4 old value kept until zero", hia, 5);
    measure(ticks, hia, hib, clks, peak, bad, slow ? 8 : 1);
    chk("R4 new value after zero", hia, 30);
  endtask

  task automatic flag_test(input int slow);
    wr(3'd0, 12);
    wr(3'd1, 8);
    wr(3'd2, 4);
    wr(3'd3, mk_ctrl(M_NI, M_NI, 0, slow));
    sync_bottom();
    sync_bottom();
    wr(3'd4, 7);
    chk("R6 clear all A", int'(flag_a), 0);
    chk("R6 clear all B", int'(flag_b), 0);
    chk("R5 clear ovf", int'(flag_ovf), 0);
    while (cnt_o != 4) next_tick();
    chk("R6 B not yet set at match value", int'(flag_b), 0);
    next_tick();
    chk("R6 B set after leaving match", int'(flag_b), 1);
    chk("R6 A still clear", int'(flag_a), 0);
    while (cnt_o != 12) next_tick();
    chk("R5 ovf clear before zero", int'(flag_ovf), 0);
    chk("R6 A set after passing match", int'(flag_a), 1);
    wr(3'd4, 1);
    chk("R6 selective clear of A", int'(flag_a), 0);
    chk("R6 B untouched by A clear", int'(flag_b), 1);
    sync_bottom();
    chk("R5 ovf set on arrival at zero", int'(flag_ovf), 1);
    chk("R6 A set again on way down", int'(flag_a), 1);
  endtask

  task automatic toggle_test(input int slow);
    int ticks, hia, hib, clks, peak, bad, span;
    logic lv;
    wr(3'd0, 99);
    wr(3'd1, 7);
    wr(3'd2, 3);
    wr(3'd3, mk_ctrl(M_TGL, M_NI, 1, slow));
    sync_bottom();
    sync_bottom();
    measure(ticks, hia, hib, clks, peak, bad, slow ? 8 : 1);
    chk("R10 TOP from channel A", ticks, 14);
    chk("R10 channel B against A-derived TOP", hib, 6);
    lv = pwm_a;
    while (pwm_a == lv) next_tick();
    for (int k = 0; k < 2; k++) begin
      lv = pwm_a;
      span = 0;
      do begin
        next_tick();
        span++;
      end while (pwm_a == lv);
      chk("R10 toggle half period", span, 14);
    end
    // toggle on B and toggle on A without TOP select stay low
    run_pwm(6, 3, 3, M_TGL, M_TGL, slow, "R11");
  endtask

  initial begin
    int top, ca, cb, ma, mb, sl;
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R12 reset counter", int'(cnt_o), 0);
    chk("R11 reset pin A", int'(pwm_a), 0);
    chk("R11 reset pin B", int'(pwm_b), 0);
    chk("R6 reset flags", int'(flag_a) + int'(flag_b) + int'(flag_ovf), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) begin
      run_pwm(10, 4, 7, M_NI, M_INV, s, "R7");
      run_pwm(10, 0, 10, M_NI, M_NI, s, "R8");
      run_pwm(10, 0, 12, M_INV, M_INV, s, "R9");
      run_pwm(9, 3, 8, M_OFF, M_NI, s, "R11");
      run_pwm(0, 1, 0, M_NI, M_NI, s, "R1");
      buffer_test(s);
      flag_test(s);
      toggle_test(s);
    end
    for (int i = 0; i < 12; i++) begin
      top = 2 + int'($urandom_range(0, 28));
      ca  = int'($urandom_range(0, top + 2));
      cb  = int'($urandom_range(0, top + 2));
      ma  = M_NI + int'($urandom_range(0, 1));
      mb  = M_NI + int'($urandom_range(0, 1));
      sl  = int'($urandom_range(0, 1));
      run_pwm(top, ca, cb, ma, mb, sl, "R7");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule